// File: doc/BRIEF.md
# Programmable Pulse Generator Channel

This block produces a repeating two-phase waveform: a LOW phase followed by a HIGH phase, each lasting a programmed number of count ticks. The count tick comes from a selectable divider of the system clock. Two mode bits change how the block counts. One bit widens the phase counter so that two 8-bit reload bytes act as a single 16-bit length. The other bit puts an 8-bit prescaler stage in front of the phase counter, so that the phase counter advances only on the prescaler's borrow pulses.

Three start sources are available, selected by priority. An external trigger pulse can start the channel. A gate input can run the channel between an active edge and the opposite edge, with the polarity selectable. A plain enable level can also run it. An invert input flips the output, and this includes the level the output rests at while the channel is halted. All control fields arrive as plain input ports.

Top module: `pulse_gen_channel`

## Requirements
- R1: While running, the output is LOW for (lowReload+1) timer ticks and then HIGH for (highReload+1) timer ticks. This pair of phases repeats.
- R2: clkSel picks the count tick rate. Code 00 gives a tick on every clock, 01 one tick every 4 clocks, 10 one tick every 16 clocks, and 11 one tick every 64 clocks.
- R3: While halted, pulseOut equals invert, so it rests LOW when invert=0. Setting invert=1 flips both phases of the output.
- R4: Start source priority: srcTrig=1 selects the trigger input. Otherwise srcGate=1 selects the gate input. Otherwise regEnable controls the channel. An unselected source has no effect.
- R5: In gate mode with edgeSel=0, a rising edge of gateIn starts the channel and a falling edge stops it. With edgeSel=1 the edges swap roles. Entering gate mode while gateIn is already at its active level does not start the channel.
- R6: In register mode the channel runs while regEnable=1 and halts when regEnable=0.
- R7: In trigger mode a one-cycle pulse on trigIn starts the channel, and the channel keeps running. When the source then moves to register mode, the channel's run state follows regEnable.
- R8: mode[1]=1 chains the prescaler. The phase counter then advances once every (preReload+1) count ticks.
- R9: mode[0]=1 uses the full 16 bits of lowReload and highReload. With mode[0]=0 only bits [7:0] of each are used.
- R10: When the channel stops, pulseOut returns to the idle level on the next clock edge. A restart always begins with a complete LOW phase.
- R11: A reload value is sampled when its phase begins. A change made during a phase takes effect from the next phase of that kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkSel | input | 2 | Count tick divider select |
| mode | input | 2 | Bit 0: 16-bit phase length; bit 1: prescaler chained |
| lowReload | input | 16 | LOW phase length minus one |
| highReload | input | 16 | HIGH phase length minus one |
| preReload | input | 8 | Prescaler divide ratio minus one |
| srcTrig | input | 1 | Select trigger input as start source |
| srcGate | input | 1 | Select gate input as start source |
| edgeSel | input | 1 | Gate polarity: 0 runs from rising to falling edge, 1 runs from falling to rising edge |
| regEnable | input | 1 | Enable level used in register mode |
| gateIn | input | 1 | External gate |
| trigIn | input | 1 | External start pulse |
| invert | input | 1 | Output inversion |
| pulseOut | output | 1 | Generated waveform |

## Verification
The hardest cases to reach are the ones where a source choice and a signal level interact. Examples are entering gate mode with gateIn already at its active level, and raising a gate edge while the trigger source has priority. The stimulus sets up the level first with the gate not selected, lets at least one clock pass, and only then switches the selector. It then watches for several cycles with one-tick phases, so that any start would show up as a HIGH sample. Reload changes during a phase are applied partway through a measured LOW phase, and the lengths of the following phases show which value was sampled.

// File: rtl/pulse_gen_pkg.sv
package pulse_gen_pkg;
  localparam int DIV_W = 6;

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic dec;
  } cnt_strobe_t;

  function automatic logic [DIV_W-1:0] divLimit(input logic [1:0] sel);
    logic [DIV_W:0] full;
    full = (DIV_W+1)'(1) << (2 * sel);
    return DIV_W'(full - 1'b1);
  endfunction
endpackage

// File: rtl/pulse_gen_ctrl.sv
module pulse_gen_ctrl
  import pulse_gen_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       clkSel,
  input  logic             chainPre,
  input  logic [PRE_W-1:0] preReload,
  input  logic             srcTrig,
  input  logic             srcGate,
  input  logic             edgeSel,
  input  logic             regEnable,
  input  logic             gateIn,
  input  logic             trigIn,
  input  logic             cntZero,
  output cnt_strobe_t      strb,
  output logic             run,
  output logic             phaseHigh
);
  logic [DIV_W-1:0] divCnt;
  logic [PRE_W-1:0] preCnt;
  logic             gateActPrev;
  logic             gateAct, gateOn, gateOff;
  logic             countTick, borrow, timerTick, step, endPhase;
  logic             runNext;

  assign gateAct = gateIn ^ edgeSel;
  assign gateOn  = gateAct & ~gateActPrev;
  assign gateOff = ~gateAct & gateActPrev;

  always_comb begin
    runNext = run;
    if (srcTrig) begin
      if (trigIn) runNext = 1'b1;
    end else if (srcGate) begin
      if (gateOn)       runNext = 1'b1;
      else if (gateOff) runNext = 1'b0;
    end else begin
      runNext = regEnable;
    end
  end

  assign countTick = run && (divCnt >= divLimit(clkSel));
  assign borrow    = countTick && (preCnt == '0);
  assign timerTick = chainPre ? borrow : countTick;
  assign step      = run && timerTick;
  assign endPhase  = step && cntZero;

  always_comb begin
    strb.loadLow  = !run || (endPhase && phaseHigh);
    strb.loadHigh = endPhase && !phaseHigh;
    strb.dec      = step && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run         <= 1'b0;
      gateActPrev <= 1'b0;
      divCnt      <= '0;
      preCnt      <= '0;
      phaseHigh   <= 1'b0;
    end else begin
      run         <= runNext;
      gateActPrev <= gateAct;
      if (!run || countTick) divCnt <= '0;
      else                   divCnt <= divCnt + 1'b1;
      if (!run || borrow)    preCnt <= preReload;
      else if (countTick)    preCnt <= preCnt - 1'b1;
      if (!run)              phaseHigh <= 1'b0;
      else if (endPhase)     phaseHigh <= !phaseHigh;
    end
  end
endmodule

// File: rtl/pulse_gen_dp.sv
module pulse_gen_dp
  import pulse_gen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  cnt_strobe_t  strb,
  input  logic [W-1:0] lowVal,
  input  logic [W-1:0] highVal,
  output logic [W-1:0] cnt,
  output logic         cntZero
);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.loadLow)  cnt <= lowVal;
    else if (strb.loadHigh) cnt <= highVal;
    else if (strb.dec)      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pulse_gen_channel.sv
module pulse_gen_channel
  import pulse_gen_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int PRE_W  = 8,
  localparam int WIDE_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        clkSel,
  input  logic [1:0]        mode,
  input  logic [WIDE_W-1:0] lowReload,
  input  logic [WIDE_W-1:0] highReload,
  input  logic [PRE_W-1:0]  preReload,
  input  logic              srcTrig,
  input  logic              srcGate,
  input  logic              edgeSel,
  input  logic              regEnable,
  input  logic              gateIn,
  input  logic              trigIn,
  input  logic              invert,
  output logic              pulseOut
);
  cnt_strobe_t       strb;
  logic              run, phaseHigh, cntZero;
  logic [WIDE_W-1:0] cnt, lowVal, highVal;

  assign lowVal  = mode[0] ? lowReload  : {{LANE_W{1'b0}}, lowReload[LANE_W-1:0]};
  assign highVal = mode[0] ? highReload : {{LANE_W{1'b0}}, highReload[LANE_W-1:0]};

  pulse_gen_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .chainPre(mode[1]),
    .preReload(preReload), .srcTrig(srcTrig), .srcGate(srcGate),
    .edgeSel(edgeSel), .regEnable(regEnable), .gateIn(gateIn),
    .trigIn(trigIn), .cntZero(cntZero), .strb(strb), .run(run),
    .phaseHigh(phaseHigh)
  );

  pulse_gen_dp #(.W(WIDE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lowVal(lowVal),
    .highVal(highVal), .cnt(cnt), .cntZero(cntZero)
  );

  assign pulseOut = (run & phaseHigh) ^ invert;
endmodule

// File: rtl/pulse_gen_channel_sva.sv
module pulse_gen_channel_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         srcTrig,
  input logic         srcGate,
  input logic         edgeSel,
  input logic         regEnable,
  input logic         gateIn,
  input logic         invert,
  input logic         pulseOut,
  input logic         run,
  input logic         phaseHigh,
  input logic [W-1:0] cnt
);
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> pulseOut == invert);

  assert_start_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> pulseOut == invert);

  assert_reg_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!srcTrig && !srcGate && !regEnable) |=> pulseOut == invert);

  assert_gate_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!srcTrig && srcGate && !edgeSel && $fell(gateIn)) |=> !run);

  assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (run && cnt != '0) |=> (!run || $stable(phaseHigh)));
endmodule

bind pulse_gen_channel pulse_gen_channel_sva #(.W(WIDE_W)) u_sva (
  .clk(clk), .rstN(rstN), .srcTrig(srcTrig), .srcGate(srcGate),
  .edgeSel(edgeSel), .regEnable(regEnable), .gateIn(gateIn),
  .invert(invert), .pulseOut(pulseOut), .run(run),
  .phaseHigh(phaseHigh), .cnt(cnt)
);

// File: tb/tb_pulse_gen_channel.sv
module tb_pulse_gen_channel;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  clkSel = 2'b00;
  logic [1:0]  mode = 2'b00;
  logic [15:0] lowReload = '0;
  logic [15:0] highReload = '0;
  logic [7:0]  preReload = '0;
  logic        srcTrig = 1'b0, srcGate = 1'b0, edgeSel = 1'b0;
  logic        regEnable = 1'b0, gateIn = 1'b0, trigIn = 1'b0, invert = 1'b0;
  logic        pulseOut;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_gen_channel dut (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .mode(mode),
    .lowReload(lowReload), .highReload(highReload), .preReload(preReload),
    .srcTrig(srcTrig), .srcGate(srcGate), .edgeSel(edgeSel),
    .regEnable(regEnable), .gateIn(gateIn), .trigIn(trigIn),
    .invert(invert), .pulseOut(pulseOut)
  );

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic measure(input logic level, output int n);
    n = 0;
    while (pulseOut === level && n < CAP) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic regStart();
    @(negedge clk) regEnable = 1'b1;
    @(negedge clk);
  endtask

  task automatic regStop();
    regEnable = 1'b0;
    @(negedge clk);
    chk(pulseOut, invert, "R10 idle after stop");
  endtask

  task automatic runShape(input int expLow, input int expHigh, input string tag);
    int n;
    regStart();
    measure(invert, n);        chk(n, expLow, {tag, " low"});
    measure(!invert, n);       chk(n, expHigh, {tag, " high"});
    measure(invert, n);        chk(n, expLow, {tag, " low again"});
    regStop();
  endtask

  task automatic staysIdle(input int cycles, input string tag);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pulseOut !== invert) bad++;
    end
    chk(bad, 0, tag);
  endtask

  task automatic testReset();
    chk(pulseOut, 0, "R3 reset idle LOW");
  endtask

  task automatic testBasic();
    lowReload = 16'd2; highReload = 16'd4;
    runShape(3, 5, "R1 R6 basic");
  endtask

  task automatic testClkSel();
    clkSel = 2'b01; lowReload = 16'd1; highReload = 16'd0;
    runShape(8, 4, "R2 div4");
    clkSel = 2'b10; lowReload = 16'd0; highReload = 16'd0;
    runShape(16, 16, "R2 div16");
    clkSel = 2'b11; lowReload = 16'd0; highReload = 16'd1;
    runShape(64, 128, "R2 div64");
    clkSel = 2'b00;
  endtask

  task automatic testInvert();
    invert = 1'b1;
    @(negedge clk);
    chk(pulseOut, 1, "R3 inverted idle");
    lowReload = 16'd1; highReload = 16'd2;
    runShape(2, 3, "R3 inverted run");
    invert = 1'b0;
  endtask

  task automatic testWide();
    mode = 2'b01; lowReload = 16'h0102; highReload = 16'h0003;
    runShape(259, 4, "R9 16-bit");
    mode = 2'b00;
    runShape(3, 4, "R9 8-bit ignores upper byte");
  endtask

  task automatic testPrescale();
    mode = 2'b10; preReload = 8'd2; lowReload = 16'd1; highReload = 16'd0;
    runShape(6, 3, "R8 chained 8+8");
    mode = 2'b11; preReload = 8'd1; lowReload = 16'h0100; highReload = 16'd0;
    runShape(514, 2, "R8 R9 chained wide");
    mode = 2'b00; preReload = 8'd0;
  endtask

  task automatic testGate();
    int n;
    lowReload = 16'd1; highReload = 16'd2;
    srcGate = 1'b1; edgeSel = 1'b0;
    @(negedge clk) gateIn = 1'b1;
    @(negedge clk);
    measure(0, n); chk(n, 2, "R5 rising start low");
    @(negedge clk) gateIn = 1'b0;
    @(negedge clk);
    chk(pulseOut, 0, "R5 falling stop");
    lowReload = 16'd0; highReload = 16'd0;
    staysIdle(4, "R5 stays stopped");
    srcGate = 1'b0; edgeSel = 1'b1; gateIn = 1'b1;
    @(negedge clk); @(negedge clk);
    srcGate = 1'b1;
    staysIdle(4, "R5 no start without edge");
    lowReload = 16'd1; highReload = 16'd2;
    gateIn = 1'b0;
    @(negedge clk);
    measure(0, n); chk(n, 2, "R5 falling start low");
    measure(1, n); chk(n, 3, "R5 falling start high");
    gateIn = 1'b1;
    @(negedge clk);
    chk(pulseOut, 0, "R5 rising stop with edgeSel=1");
    srcGate = 1'b0; edgeSel = 1'b0; gateIn = 1'b0;
    @(negedge clk);
    srcGate = 1'b1; edgeSel = 1'b0;
    lowReload = 16'd0; highReload = 16'd0;
    @(negedge clk);
    regEnable = 1'b1;
    staysIdle(4, "R4 enable ignored in gate mode");
    regEnable = 1'b0; srcGate = 1'b0;
    @(negedge clk);
  endtask

  task automatic testTrigger();
    int n;
    lowReload = 16'd0; highReload = 16'd0;
    @(negedge clk) trigIn = 1'b1;
    @(negedge clk) trigIn = 1'b0;
    staysIdle(4, "R4 trigger ignored in register mode");
    srcTrig = 1'b1; srcGate = 1'b1;
    @(negedge clk) gateIn = 1'b1;
    staysIdle(4, "R4 gate edge ignored in trigger mode");
    gateIn = 1'b0; srcGate = 1'b0;
    lowReload = 16'd2; highReload = 16'd1;
    @(negedge clk) trigIn = 1'b1;
    @(negedge clk) trigIn = 1'b0;
    measure(0, n); chk(n, 3, "R7 trigger start low");
    measure(1, n); chk(n, 2, "R7 trigger high");
    measure(0, n); chk(n, 3, "R7 keeps running");
    srcTrig = 1'b0;
    @(negedge clk);
    chk(pulseOut, 0, "R7 leave trigger mode stops");
  endtask

  task automatic testRestart();
    int n;
    lowReload = 16'd3; highReload = 16'd2;
    regStart();
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk(pulseOut, 1, "R10 in high phase before stop");
    regStop();
    regStart();
    measure(0, n); chk(n, 4, "R10 restart full low");
    regStop();
  endtask

  task automatic testReloadTiming();
    int n;
    lowReload = 16'd3; highReload = 16'd3;
    regStart();
    @(negedge clk);
    highReload = 16'd1; lowReload = 16'd0;
    measure(0, n); chk(n + 1, 4, "R11 low keeps sampled value");
    measure(1, n); chk(n, 2, "R11 high uses new value");
    measure(0, n); chk(n, 1, "R11 next low uses new value");
    regStop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBasic();
    testClkSel();
    testInvert();
    testWide();
    testPrescale();
    testGate();
    testTrigger();
    testRestart();
    testReloadTiming();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule